// File: doc/BRIEF.md
# UART Line Status Generator

This block builds the 8-bit line status word of a UART that has receive and transmit FIFOs. It watches the strobes and levels around a receive FIFO whose entries each carry their own error flags (parity, framing, break), the empty state of the transmit FIFO and the idle state of the transmit shifter, and it folds them into one status byte that software polls or that feeds an interrupt decoder.

The receive side and the transmit side of the word are independent, so software can poll either half alone. The receive half reports data ready, sticky per-condition error bits and a summary error bit. The summary bit is driven by an up/down count of errored bytes still held in the receive FIFO, so it stays set until the last bad byte has left the FIFO, not just until the first one does. The FIFO storage, serial framing and register decode are outside this block.

Top module: `uart_line_status`

## Requirements
- R1: Bit 0 (data ready) equals the inverse of `rxEmpty` in the same cycle.
- R2: A push while `rxFull` is high is an overrun: bit 1 reads 1 from the next cycle and holds until a status read.
- R3: Error flag vectors use index 0 = parity, 1 = framing, 2 = break; these drive status bits 2, 3 and 4. A byte becomes the head on the first non-empty cycle after reset, after a flush or after an empty cycle, and on each non-empty cycle following a pop. When a head appears with a flag set, the matching bit reads 1 from the next cycle, captured once per head.
- R4: A status read clears bits 1 to 4 from the next cycle; a new overrun or head capture in the same cycle wins over the clear.
- R5: Bit 5 equals `txEmpty` in the same cycle, whatever the receive side does.
- R6: Bit 6 is 1 only when `txEmpty` and `txShiftIdle` are both 1.
- R7: Bit 7 is 1 from the cycle after an accepted push of a byte with any flag set, and stays 1 until every such byte has been popped; a pop of an errored head decrements the count.
- R8: A flush sets the errored-byte count to zero from the next cycle and overrides a push or pop in the same cycle.
- R9: A push while full is discarded: it leaves the errored-byte count unchanged even if its flags are set.
- R10: After reset bits 1 to 4 and bit 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPush | input | 1 | Receive FIFO write strobe |
| rxPushErr | input | 3 | Flags of the byte being written (0 parity, 1 framing, 2 break) |
| rxFull | input | 1 | Receive FIFO full |
| rxPop | input | 1 | Receive FIFO read strobe |
| rxHeadErr | input | 3 | Flags of the byte at the FIFO head |
| rxEmpty | input | 1 | Receive FIFO empty |
| rxFlush | input | 1 | Receive FIFO clear strobe |
| txEmpty | input | 1 | Transmit FIFO empty |
| txShiftIdle | input | 1 | Transmit shift register idle |
| statusRead | input | 1 | Line status register read strobe |
| lineStatus | output | 8 | Line status word |

## Verification
The receive path is driven with clean bytes, single-flag bytes and mixed-flag bytes, so that a head capture of the wrong flag index or a count that moves on clean bytes shows up as a wrong bit 2 to 4 or 7. Pushes against a full FIFO, with and without flags, separate the overrun bit from the error count, and a flush issued together with an errored push tells apart flush priority from push priority. Status reads are issued both alone and in the same cycle as a new overrun, which separates clear-wins from set-wins behaviour, and the transmit levels are swept through all combinations to show bits 5 and 6 apart.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int ERR_W = 3;
  localparam int LSR_W = 8;

  typedef struct packed {
    logic errPush;
    logic errPop;
    logic flush;
    logic overrun;
    logic capture;
    logic clearSticky;
  } lsrStrobes_t;
endpackage

// File: rtl/uart_lsr_ctrl.sv
module uart_lsr_ctrl
  import uart_lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxPush,
  input  logic [ERR_W-1:0] rxPushErr,
  input  logic             rxFull,
  input  logic             rxPop,
  input  logic [ERR_W-1:0] rxHeadErr,
  input  logic             rxEmpty,
  input  logic             rxFlush,
  input  logic             statusRead,
  output lsrStrobes_t      strb
);
  logic headSeen;

  always_comb begin
    strb.flush       = rxFlush;
    strb.overrun     = rxPush && rxFull;
    strb.errPush     = rxPush && !rxFull && (|rxPushErr) && !rxFlush;
    strb.errPop      = rxPop && !rxEmpty && (|rxHeadErr) && !rxFlush;
    strb.capture     = !rxEmpty && !headSeen && !rxFlush;
    strb.clearSticky = statusRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) headSeen <= 1'b0;
    else if (rxFlush || rxPop || rxEmpty) headSeen <= 1'b0;
    else headSeen <= 1'b1;
  end

  AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !rxPop && !rxFlush) |=> !strb.capture); // R3
endmodule

// File: rtl/uart_lsr_datapath.sv
module uart_lsr_datapath
  import uart_lsr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsrStrobes_t      strb,
  input  logic [ERR_W-1:0] rxHeadErr,
  output logic             overrunFlag,
  output logic [ERR_W-1:0] errSticky,
  output logic             anyErrHeld
);
  logic [CNT_W-1:0] errCount;

  always_ff @(posedge clk) begin
    if (!rstN) errCount <= '0;
    else if (strb.flush) errCount <= '0;
    else begin
      case ({strb.errPush, strb.errPop})
        2'b10:   errCount <= errCount + CNT_W'(1);
        2'b01:   errCount <= errCount - CNT_W'(1);
        default: errCount <= errCount;
      endcase
    end
  end

  assign anyErrHeld = (errCount != '0);

  always_ff @(posedge clk) begin
    if (!rstN) overrunFlag <= 1'b0;
    else if (strb.overrun) overrunFlag <= 1'b1;
    else if (strb.clearSticky) overrunFlag <= 1'b0;
  end

  for (genvar i = 0; i < ERR_W; i++) begin : gSticky
    always_ff @(posedge clk) begin
      if (!rstN) errSticky[i] <= 1'b0;
      else if (strb.capture && rxHeadErr[i]) errSticky[i] <= 1'b1;
      else if (strb.clearSticky) errSticky[i] <= 1'b0;
    end
  end

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (errCount == '0)); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.overrun |=> overrunFlag); // R2
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearSticky && !strb.overrun) |=> !overrunFlag); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errPop && !strb.errPush) |-> (errCount != '0)); // R7
  AST_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.overrun && !strb.errPop && !strb.flush) |=> (errCount == $past(errCount))); // R9
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_lsr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPush,
  input  logic [2:0] rxPushErr,
  input  logic       rxFull,
  input  logic       rxPop,
  input  logic [2:0] rxHeadErr,
  input  logic       rxEmpty,
  input  logic       rxFlush,
  input  logic       txEmpty,
  input  logic       txShiftIdle,
  input  logic       statusRead,
  output logic [7:0] lineStatus
);
  lsrStrobes_t      strb;
  logic             overrunFlag;
  logic [ERR_W-1:0] errSticky;
  logic             anyErrHeld;

  uart_lsr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .rxPush(rxPush), .rxPushErr(rxPushErr), .rxFull(rxFull),
    .rxPop(rxPop), .rxHeadErr(rxHeadErr), .rxEmpty(rxEmpty),
    .rxFlush(rxFlush), .statusRead(statusRead), .strb(strb)
  );

  uart_lsr_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxHeadErr(rxHeadErr),
    .overrunFlag(overrunFlag), .errSticky(errSticky), .anyErrHeld(anyErrHeld)
  );

  assign lineStatus = {anyErrHeld, txEmpty && txShiftIdle, txEmpty,
                       errSticky, overrunFlag, !rxEmpty};

  AST_TEMT_HAS_THRE: assert property (@(posedge clk) disable iff (!rstN)
    lineStatus[6] |-> lineStatus[5]); // R6
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rstN |=> (lineStatus[7] == 1'b0 && lineStatus[4:1] == 4'b0)); // R10
endmodule

// File: tb/uart_line_status_tb_top.sv
module uart_line_status_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxPush = 0, rxFull = 0, rxPop = 0, rxEmpty = 1, rxFlush = 0;
  logic txEmpty = 1, txShiftIdle = 1, statusRead = 0;
  logic [2:0] rxPushErr = '0, rxHeadErr = '0;
  logic [7:0] lineStatus;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  // bench model state
  bit mOvr = 0, mSeen = 0;
  bit [2:0] mErr = '0;
  int mCnt = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_line_status dut_i (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxPushErr(rxPushErr),
    .rxFull(rxFull), .rxPop(rxPop), .rxHeadErr(rxHeadErr), .rxEmpty(rxEmpty),
    .rxFlush(rxFlush), .txEmpty(txEmpty), .txShiftIdle(txShiftIdle),
    .statusRead(statusRead), .lineStatus(lineStatus)
  );

  function automatic void compare(logic [7:0] exp, string tag);
    checks++;
    if (lineStatus !== exp) begin
      fails++;
      $display("FAIL %s: lineStatus=%02h expected=%02h", tag, lineStatus, exp);
    end
  endfunction

  // driver: applies one cycle of stimulus and predicts the result
  task automatic step(input bit push, input bit [2:0] pErr, input bit pop,
                      input bit flush, input bit rd, input bit full,
                      input bit empty, input bit [2:0] head,
                      input bit txE, input bit txI, input string tag);
    bit cap;
    @(negedge clk);
    rxPush = push; rxPushErr = pErr; rxPop = pop; rxFlush = flush;
    statusRead = rd; rxFull = full; rxEmpty = empty; rxHeadErr = head;
    txEmpty = txE; txShiftIdle = txI;
    cap = !empty && !mSeen && !flush;
    if (flush) mCnt = 0;
    else begin
      if (push && !full && (|pErr)) mCnt++;
      if (pop && !empty && (|head)) mCnt--;
    end
    mOvr = (push && full) || (mOvr && !rd);
    for (int i = 0; i < 3; i++)
      mErr[i] = (cap && head[i]) || (mErr[i] && !rd);
    mSeen = !(flush || pop || empty);
    @(posedge clk);
    #1;
    rxPush = 0; rxPop = 0; rxFlush = 0; statusRead = 0;
    expQ.push_back({mCnt != 0, txE && txI, txE, mErr, mOvr, !empty});
    tagQ.push_back(tag);
  endtask

  // monitor: compares each predicted word against the design
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (expQ.size() > 0) compare(expQ.pop_front(), tagQ.pop_front());
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    compare(8'h60, "R10 reset state");
    //   push pErr   pop flush rd full empty head    txE txI
    step(0, 3'b000, 0, 0, 0, 0, 1, 3'b000, 0, 1, "R5 R6 tx busy");
    step(0, 3'b000, 0, 0, 0, 0, 1, 3'b000, 1, 0, "R5 R6 shifter busy");
    step(0, 3'b000, 0, 0, 0, 0, 1, 3'b000, 1, 1, "R6 both idle");
    step(1, 3'b000, 0, 0, 0, 0, 1, 3'b000, 1, 1, "R7 clean push no count");
    step(1, 3'b001, 0, 0, 0, 0, 0, 3'b000, 1, 1, "R1 R7 errored push");
    step(0, 3'b000, 1, 0, 0, 0, 0, 3'b000, 0, 0, "R7 pop clean head");
    step(0, 3'b000, 0, 0, 0, 0, 0, 3'b001, 0, 1, "R3 parity head capture");
    step(0, 3'b000, 0, 0, 1, 0, 0, 3'b001, 1, 1, "R4 read clears parity");
    step(0, 3'b000, 0, 0, 0, 0, 0, 3'b001, 1, 1, "R3 no recapture");
    step(0, 3'b000, 1, 0, 0, 0, 0, 3'b001, 1, 1, "R7 pop errored head");
    step(0, 3'b000, 0, 0, 0, 0, 1, 3'b000, 1, 1, "R1 R7 empty again");
    step(1, 3'b010, 0, 0, 0, 1, 0, 3'b000, 1, 1, "R2 R9 push while full");
    step(1, 3'b000, 0, 0, 1, 1, 0, 3'b000, 1, 1, "R4 overrun wins read");
    step(0, 3'b000, 0, 0, 1, 0, 0, 3'b000, 1, 1, "R4 read clears overrun");
    step(1, 3'b010, 0, 0, 0, 0, 0, 3'b000, 1, 1, "R7 framing push");
    step(1, 3'b100, 0, 0, 0, 0, 0, 3'b000, 1, 1, "R7 break push");
    step(1, 3'b110, 0, 1, 0, 0, 0, 3'b000, 1, 1, "R8 flush beats push");
    step(0, 3'b000, 0, 0, 0, 0, 1, 3'b000, 1, 1, "R8 after flush");
    step(0, 3'b000, 0, 0, 0, 0, 0, 3'b110, 1, 1, "R3 framing and break");
    step(0, 3'b000, 0, 0, 1, 0, 0, 3'b110, 1, 0, "R4 read clears flags");
    step(0, 3'b000, 0, 0, 0, 0, 0, 3'b110, 0, 0, "R5 tx busy rx held");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule